// File: doc/BRIEF.md
# Quasi-Bidirectional Port Expander with I2C Slave Interface

This block is an I2C slave that owns an 8-bit quasi-bidirectional port. The bus lines arrive as oversampled inputs on the system clock. Each line passes through a two-flop synchronizer and a counting glitch filter before any START or STOP condition or data bit is decoded. The slave answers at a 7-bit address. The upper four bits of that address are fixed, and three select inputs supply the lower three, so up to eight of these blocks can share one bus.

There is no direction register. Each pin has one latch bit. A latch bit of 1 leaves the pin released: only the weak pull-up is active, so the pin can serve as an input. A latch bit of 0 drives the pin low. When a latch bit moves from 0 to 1, a strong pull-up enable is pulsed for that pin to speed up the rising edge. The pulse ends at the next SCL falling edge.

A write transaction loads every received data byte into the latch. A read transaction returns fresh samples of the pin inputs for as long as the master keeps acknowledging. The pad circuitry, the current sources and the protection structures sit outside this block.

Top module: `qbd_port_i2c`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 0100 followed by `addr_sel_i[2:0]`, sent MSB first. Bit 0 of the address byte selects a read when it is 1 and a write when it is 0.
- R2: In a write transaction, every data byte is acknowledged and becomes the new latch value. Several bytes may follow one address, and each replaces the one before. SDA is released after each acknowledge clock.
- R3: In a read transaction, each returned byte is a sample of `port_in_i`, sent MSB first. The slave keeps sending fresh samples while the master acknowledges (SDA low). After a master not-acknowledge (SDA high), the slave releases SDA.
- R4: After reset, all latch bits are 1, `pin_low_o` is 0, `pin_boost_o` is 0 and `sda_pull_o` is 0.
- R5: For every bit, `pin_low_o` is 1 exactly when the latch bit is 0.
- R6: A write that changes a latch bit from 0 to 1 sets that bit of `pin_boost_o`. A bit that was already 1 is not pulsed. Every boost bit is cleared at the next filtered SCL falling edge.
- R7: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts the address phase and discards a partly received byte. SCL pulses after a STOP and before the next START are ignored. `sda_pull_o` changes only while SCL is low.
- R8: When the address does not match, the slave sends no acknowledge and ignores the bus until the next START. In particular, it ignores any data bytes that follow.
- R9: A pulse on SCL or SDA that is shorter than `FILT_CYC` clock cycles is ignored.
- R10: New latch data takes effect during the acknowledge clock of its byte. The old value is still present after the byte's last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_sel_i | input | 3 | Low three bits of the slave address |
| port_in_i | input | 8 | Sensed level of each port pin |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| pin_low_o | output | 8 | Per-pin strong low-side enable |
| pin_boost_o | output | 8 | Per-pin transient strong pull-up enable |

## Verification
Two events fall in the same clock cycle: the SCL falling edge that ends a write byte's acknowledge clock clears any pending boost pulses, and it also makes the slave let go of SDA. The bench writes bytes that raise some latch bits and lower others. It observes the boost enables and the low enables during the acknowledge high phase, then samples a few cycles after that SCL falls and expects both a zero boost vector and a released SDA. Glitches shorter than the filter window are placed on SDA while SCL is high, where they would otherwise read as START or STOP, and on SCL while it is low, where they would otherwise add a bit. The latch value that results from each byte shows whether the glitch was rejected.

// File: rtl/qbd_port_i2c.sv
module qbd_port_i2c #(
  parameter int          FILT_CYC = 4,
  parameter logic [3:0]  ADDR_HI  = 4'b0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_sel_i,
  input  logic [7:0] port_in_i,
  output logic       sda_pull_o,
  output logic [7:0] pin_low_o,
  output logic [7:0] pin_boost_o
);

  localparam int         FC_W     = $clog2(FILT_CYC + 1);
  localparam logic [3:0] BYTE_END = 4'd8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_RX, S_WACK, S_TX, S_MACK
  } st_t;

  logic [1:0] raw, s1, s2, filt, filt_q;
  logic       scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;
  st_t        st;
  logic [3:0] bcnt;
  logic [7:0] sh, lat, boost;
  logic       rw, mack;

  assign raw = {scl_i, sda_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1     <= 2'b11;
      s2     <= 2'b11;
      filt_q <= 2'b11;
    end else begin
      s1     <= raw;
      s2     <= s1;
      filt_q <= filt;
    end

  for (genvar g = 0; g < 2; g++) begin : g_flt
    logic [FC_W-1:0] cnt;
    logic            f_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        f_q <= 1'b1;
      end else if (s2[g] != f_q) begin
        if (cnt == FC_W'(FILT_CYC - 1)) begin
          f_q <= s2[g];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    assign filt[g] = f_q;
  end

  assign scl_f     = filt[1];
  assign sda_f     = filt[0];
  assign scl_rise  = scl_f & ~filt_q[1];
  assign scl_fall  = ~scl_f & filt_q[1];
  assign start_det = scl_f & filt_q[1] & filt_q[0] & ~sda_f;
  assign stop_det  = scl_f & filt_q[1] & ~filt_q[0] & sda_f;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_IDLE;
      bcnt  <= '0;
      sh    <= '0;
      lat   <= '1;
      boost <= '0;
      rw    <= 1'b0;
      mack  <= 1'b0;
    end else begin
      if (scl_fall) boost <= '0;
      if (start_det) begin
        st   <= S_ADDR;
        bcnt <= '0;
      end else if (stop_det) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_ADDR, S_RX:
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_f};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == BYTE_END) begin
              if (st == S_RX) begin
                st <= S_WACK;
              end else if (sh[7:1] == {ADDR_HI, addr_sel_i}) begin
                st <= S_AACK;
                rw <= sh[0];
              end else begin
                st <= S_IDLE;
              end
            end
          S_AACK:
            if (scl_rise && rw) begin
              sh <= port_in_i;
            end else if (scl_fall) begin
              bcnt <= '0;
              st   <= rw ? S_TX : S_RX;
            end
          S_WACK:
            if (scl_rise) begin
              lat   <= sh;
              boost <= sh & ~lat;
            end else if (scl_fall) begin
              bcnt <= '0;
              st   <= S_RX;
            end
          S_TX:
            if (scl_rise) begin
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall) begin
              if (bcnt == BYTE_END) st <= S_MACK;
              else sh <= {sh[6:0], 1'b0};
            end
          S_MACK:
            if (scl_rise) begin
              mack <= ~sda_f;
              sh   <= port_in_i;
            end else if (scl_fall) begin
              bcnt <= '0;
              st   <= mack ? S_TX : S_IDLE;
            end
          default: st <= S_IDLE;
        endcase
      end
    end

  assign sda_pull_o  = (st == S_AACK) | (st == S_WACK) | ((st == S_TX) & ~sh[7]);
  assign pin_low_o   = ~lat;
  assign pin_boost_o = boost;

endmodule

// File: rtl/qbd_port_i2c_chk.sv
module qbd_port_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       start_det,
  input logic       sda_pull_o,
  input logic [7:0] pin_low_o,
  input logic [7:0] pin_boost_o
);

  AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_low_o == 8'h00 && pin_boost_o == 8'h00 && !sda_pull_o)); // R4

  AST_BOOST_ON_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_boost_o & pin_low_o) == 8'h00); // R5

  AST_BOOST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_f) |=> pin_boost_o == 8'h00); // R6

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_f); // R7

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull_o); // R7

  AST_LATCH_IN_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_low_o) |-> $past(scl_f)); // R10

endmodule

bind qbd_port_i2c qbd_port_i2c_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_f      (scl_f),
  .start_det  (start_det),
  .sda_pull_o (sda_pull_o),
  .pin_low_o  (pin_low_o),
  .pin_boost_o(pin_boost_o)
);

// File: tb/sim_qbd_port_i2c.sv
module sim_qbd_port_i2c;

  localparam int H = 25;
  localparam logic [15:0] VEC [0:5] = '{16'h00A5, 16'h0F3C, 16'hF0FF,
                                       16'hFF00, 16'h5581, 16'hAA7E};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] asel = 3'b010;
  logic [7:0] pin_in = 8'h00;
  logic       sda_pull, sda_line;
  logic [7:0] pin_low, pin_boost;
  logic [7:0] prev = 8'hFF;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  qbd_port_i2c #(.FILT_CYC(4)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel_i(asel), .port_in_i(pin_in), .sda_pull_o(sda_pull),
    .pin_low_o(pin_low), .pin_boost_o(pin_boost)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    wt(5); sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch,
                           output logic ack, output logic [7:0] low_pre,
                           output logic [7:0] low_ack, output logic [7:0] boost_ack,
                           output logic [7:0] boost_post, output logic pull_post);
    for (int i = 7; i >= 0; i--) begin
      wt(5); sda_m = b[i];
      if (glitch == 2 && i == 3) begin
        wt(8); scl_m = 1'b1; wt(2); scl_m = 1'b0; wt(H - 15);
      end else wt(H - 5);
      scl_m = 1'b1;
      if (glitch == 1 && i == 4) begin
        wt(8); sda_m = ~sda_m; wt(2); sda_m = ~sda_m; wt(H - 10);
      end else wt(H);
      scl_m = 1'b0;
    end
    wt(5); sda_m = 1'b1; wt(H - 5);
    low_pre = pin_low;
    scl_m = 1'b1; wt(12);
    ack = ~sda_line; low_ack = pin_low; boost_ack = pin_boost;
    wt(H - 12); scl_m = 1'b0; wt(12);
    boost_post = pin_boost; pull_post = sda_pull;
  endtask

  task automatic recv_byte(input logic do_ack, input logic [7:0] nxt,
                           output logic [7:0] b, output logic pull_post);
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl_m = 1'b1; wt(12);
      b[i] = sda_line;
      wt(H - 12); scl_m = 1'b0;
    end
    pin_in = nxt;
    wt(5); sda_m = ~do_ack; wt(H - 5);
    scl_m = 1'b1; wt(H); scl_m = 1'b0;
    wt(5); sda_m = 1'b1; wt(7);
    pull_post = sda_pull;
  endtask

  task automatic addr_chk(input logic [7:0] a, input logic exp_ack, input string tag);
    logic ack, pp;
    logic [7:0] l0, l1, b0, b1;
    send_byte(a, 0, ack, l0, l1, b0, b1, pp);
    chk(tag, {7'd0, ack}, {7'd0, exp_ack});
  endtask

  task automatic wr_chk(input logic [7:0] b, input int glitch, input string tag);
    logic ack, pp;
    logic [7:0] l0, l1, b0, b1;
    send_byte(b, glitch, ack, l0, l1, b0, b1, pp);
    chk({tag, " R2 data ack"}, {7'd0, ack}, 8'd1);
    chk({tag, " R10 old value before ack"}, l0, ~prev);
    chk({tag, " R5 low enables"}, l1, ~b);
    chk({tag, " R6 boost on rising bits"}, b0, b & ~prev);
    chk({tag, " R6 boost cleared with SDA release"}, b1, 8'h00);
    chk({tag, " R2 SDA released after ack"}, {7'd0, pp}, 8'd0);
    prev = b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=%h expected=%h", 8'h01, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd, l0, l1, b0, b1;
    logic pp, ack;
    wt(4); rst_n = 1'b1; wt(10);
    chk("R4 reset low enables", pin_low, 8'h00);
    chk("R4 reset boost", pin_boost, 8'h00);
    chk("R4 reset SDA", {7'd0, sda_pull}, 8'd0);

    foreach (VEC[k]) begin
      i2c_start();
      addr_chk({4'b0100, asel, 1'b0}, 1'b1, "R1 write address ack");
      wr_chk(VEC[k][15:8], 0, "table");
      i2c_stop();
      pin_in = VEC[k][7:0];
      i2c_start();
      addr_chk({4'b0100, asel, 1'b1}, 1'b1, "R1 read address ack");
      recv_byte(1'b0, 8'h00, rd, pp);
      chk("R3 read sample", rd, VEC[k][7:0]);
      chk("R3 SDA released after nack", {7'd0, pp}, 8'd0);
      i2c_stop();
    end

    // R2: back-to-back bytes in one write
    i2c_start();
    addr_chk({4'b0100, asel, 1'b0}, 1'b1, "R1 write address ack");
    wr_chk(8'h12, 0, "burst1");
    wr_chk(8'h34, 0, "burst2");
    wr_chk(8'h56, 0, "burst3");
    i2c_stop();

    // R3: sequential read with changing pins
    pin_in = 8'h11;
    i2c_start();
    addr_chk({4'b0100, asel, 1'b1}, 1'b1, "R1 read address ack");
    recv_byte(1'b1, 8'h22, rd, pp); chk("R3 seq byte0", rd, 8'h11);
    recv_byte(1'b1, 8'h33, rd, pp); chk("R3 seq byte1", rd, 8'h22);
    recv_byte(1'b0, 8'h00, rd, pp); chk("R3 seq byte2", rd, 8'h33);
    chk("R3 SDA released after nack", {7'd0, pp}, 8'd0);
    i2c_stop();

    // R8: wrong address, data ignored
    i2c_start();
    addr_chk({4'b0100, ~asel, 1'b0}, 1'b0, "R8 mismatch no ack");
    send_byte(8'h00, 0, ack, l0, l1, b0, b1, pp);
    chk("R8 data not acked", {7'd0, ack}, 8'd0);
    chk("R8 latch untouched", l1, ~prev);
    i2c_stop();
    i2c_start();
    addr_chk({4'b1100, asel, 1'b0}, 1'b0, "R1 fixed bits mismatch");
    i2c_stop();

    // R1: other select value
    asel = 3'b101;
    i2c_start();
    addr_chk({4'b0100, 3'b101, 1'b0}, 1'b1, "R1 new select ack");
    wr_chk(8'h3C, 0, "R1 sel");
    i2c_stop();

    // R7: repeated START discards partial byte
    i2c_start();
    addr_chk({4'b0100, asel, 1'b0}, 1'b1, "R7 write address ack");
    for (int i = 0; i < 4; i++) begin
      wt(5); sda_m = 1'b0; wt(H - 5); scl_m = 1'b1; wt(H); scl_m = 1'b0;
    end
    pin_in = 8'hC6;
    i2c_start();
    addr_chk({4'b0100, asel, 1'b1}, 1'b1, "R7 restart read ack");
    recv_byte(1'b0, 8'h00, rd, pp);
    chk("R7 restart read data", rd, 8'hC6);
    i2c_stop();
    chk("R7 partial byte discarded", pin_low, ~prev);

    // R7: clocking after STOP without START is ignored
    wt(5); scl_m = 1'b0;
    send_byte(8'h00, 0, ack, l0, l1, b0, b1, pp);
    chk("R7 no ack without START", {7'd0, ack}, 8'd0);
    chk("R7 latch kept after STOP", l1, ~prev);
    i2c_stop();

    // R9: short glitches on SDA (SCL high) and SCL (SCL low)
    i2c_start();
    addr_chk({4'b0100, asel, 1'b0}, 1'b1, "R9 write address ack");
    wr_chk(8'h3C, 1, "R9 sda glitch");
    wr_chk(8'h96, 2, "R9 scl glitch");
    i2c_stop();

    wt(20);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule